// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block produces a card clock from a fast reference clock. A two-bit ratio select chooses one of four output rates: the reference divided by 8, 4 or 2, or the reference itself. The output stays low until an activation-done input is raised. A ratio change never produces a runt pulse. Before any new ratio takes over, the output is parked low for at least a set number of reference cycles.

The ratio select may come from any domain. It passes through a synchronizer and a stability filter before the block acts on it. A control state machine with three states decides when a new ratio is loaded:

- `ST_HOLD`: the output is parked low.
- `ST_DIV`: the divided clock runs.
- `ST_PASS`: the gated reference is passed straight through.

The state machine has these transitions:

- `ST_HOLD` goes to `ST_DIV` or to `ST_PASS` when activation-done is high and the low time has reached the minimum. At that moment the requested ratio is loaded.
- `ST_DIV` goes to `ST_HOLD` when a change is pending while the output is low. A change is pending when the request differs from the ratio in use, or when activation-done is low.
- `ST_PASS` goes to `ST_HOLD` as soon as a change is pending.

A flag output tells the surrounding logic whether the requested ratio is the one in use.

Top module: `clkdiv_card_clk`

## Requirements
- R1: The select encoding is `ratio_sel_i` = 2'b00 for the reference divided by 8, 2'b01 for divide by 4, 2'b11 for divide by 2, and 2'b10 for pass-through.
- R2: In every divided mode, the high and low phases of `card_clk_o` each last exactly half the output period, in whole reference cycles (4, 2 or 1).
- R3: While reset is held and right after it, `card_clk_o` is low and `ratio_ok_o` is high, with divide-by-8 as the ratio in use.
- R4: While `act_done_i` is low, `card_clk_o` stays low. When it drops, any high phase in progress ends normally and no further rising edge follows.
- R5: A select value counts as requested only after two synchronizer flops and at least 11 consecutive equal samples. A shorter excursion of the select is ignored: the flag stays high and the output rate is unchanged.
- R6: A new ratio is loaded only while the output is low and has been low for at least 10 reference cycles. The divider restarts from zero at that point. This also applies when entering and leaving pass-through and when activation-done returns.
- R7: `ratio_ok_o` is high exactly when the accepted request equals the ratio in use. After a select change, it is low 16 reference cycles later and high again once the new ratio is loaded.
- R8: In pass-through, `card_clk_o` follows the reference clock. The enable changes only while the reference is low, and the divided path is held low during this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Fast reference clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| ratio_sel_i | input | 2 | Ratio select, encoded as in R1 |
| act_done_i | input | 1 | Activation-done flag; output edges only while high |
| card_clk_o | output | 1 | Card clock output |
| ratio_ok_o | output | 1 | High when the requested ratio is in use |

## Verification
A table walks the select through every code, each step differing from the one before:

- the measured high and low runs separate the four rates and confirm the 50 % duty;
- the flag sampled mid-switch separates a deferred change from an immediate one;
- the longest low run seen across the switch shows whether the parking time was kept.

A short select excursion back to the previous code checks that the stability filter rejects it without a reload. Removing and restoring activation-done, before first use and in the fastest divided mode, checks that the output is silent while the flag is low and that edges resume only after a long low phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_DIV  = 2'd1,
        ST_PASS = 2'd2
    } div_state_e;

    localparam logic [1:0] SEL_DIV8 = 2'b00;
    localparam logic [1:0] SEL_DIV4 = 2'b01;
    localparam logic [1:0] SEL_DIV2 = 2'b11;
    localparam logic [1:0] SEL_PASS = 2'b10;

endpackage

// File: rtl/clkdiv_sel_sync.sv
module clkdiv_sel_sync #(
    parameter int         SYNC_STAGES = 2,
    parameter int         STABLE_CYC  = 11,
    parameter logic [1:0] RESET_SEL   = 2'b00
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] sel_async_i,
    output logic [1:0] sel_req_o
);
    localparam int          STAB_W    = $clog2(STABLE_CYC + 1);
    localparam logic [STAB_W-1:0] STAB_LAST = STAB_W'(STABLE_CYC - 1);

    logic [1:0]        stage_q [SYNC_STAGES];
    logic [1:0]        cand_q;
    logic [1:0]        req_q;
    logic [STAB_W-1:0] stab_q;

    // synchronizer chain, then stability filter
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= RESET_SEL;
            cand_q <= RESET_SEL;
            req_q  <= RESET_SEL;
            stab_q <= '0;
        end else begin
            stage_q[0] <= sel_async_i;
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
            if (stage_q[SYNC_STAGES-1] != cand_q) begin
                cand_q <= stage_q[SYNC_STAGES-1];
                stab_q <= '0;
            end else if (stab_q != STAB_LAST) begin
                stab_q <= stab_q + 1'b1;
            end else begin
                req_q <= cand_q;
            end
        end
    end

    assign sel_req_o = req_q;

    // R5: the request moves only after the candidate has been stable long enough
    assert_debounce_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_q != $past(req_q)) |-> ($past(stab_q) == STAB_LAST && $past(cand_q) == req_q));

endmodule

// File: rtl/clkdiv_half_cnt.sv
module clkdiv_half_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] half_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == half_i - CNT_W'(1));

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i)            cnt_q <= '0;
        else if (!run_i)      cnt_q <= '0;
        else if (tick_o)      cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    // R2: while running, the count never passes the half period
    assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i |-> (cnt_q < half_i));

endmodule

// File: rtl/clkdiv_out_gate.sv
module clkdiv_out_gate (
    input  logic ref_clk_i,
    input  logic rst_i,
    input  logic pass_req_i,
    input  logic div_clk_i,
    output logic clk_o
);
    logic pass_en_q;

    // enable moves on the falling reference edge, while the reference is low
    always_ff @(negedge ref_clk_i or posedge rst_i) begin
        if (rst_i) pass_en_q <= 1'b0;
        else       pass_en_q <= pass_req_i;
    end

    assign clk_o = pass_en_q ? ref_clk_i : div_clk_i;

    // R8: the divided path is parked low whenever the gate is open
    assert_gate_quiet_R8: assert property (@(posedge ref_clk_i) disable iff (rst_i)
        pass_en_q |-> !div_clk_i);

endmodule

// File: rtl/clkdiv_card_clk.sv
module clkdiv_card_clk
    import clkdiv_pkg::*;
#(
    parameter int MIN_PHASE   = 10,
    parameter int STABLE_CYC  = 11,
    parameter int SYNC_STAGES = 2,
    parameter int HALF_DIV8   = 4,
    parameter int HALF_DIV4   = 2,
    parameter int HALF_DIV2   = 1
) (
    input  logic       ref_clk_i,
    input  logic       rst_i,
    input  logic [1:0] ratio_sel_i,
    input  logic       act_done_i,
    output logic       card_clk_o,
    output logic       ratio_ok_o
);
    localparam int LOW_W = $clog2(MIN_PHASE + 1);
    localparam int CNT_W = $clog2(HALF_DIV8 + 1);
    localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(MIN_PHASE);

    div_state_e       state_q, state_d;
    logic [1:0]       active_q, active_d;
    logic [1:0]       req_sel;
    logic             div_q, div_d;
    logic [LOW_W-1:0] low_cnt_q, low_d;
    logic [CNT_W-1:0] half_sel;
    logic             tick;
    logic             change_pend;
    logic             pass_req;

    clkdiv_sel_sync #(
        .SYNC_STAGES (SYNC_STAGES),
        .STABLE_CYC  (STABLE_CYC),
        .RESET_SEL   (SEL_DIV8)
    ) sel_sync_i (
        .clk_i       (ref_clk_i),
        .rst_i       (rst_i),
        .sel_async_i (ratio_sel_i),
        .sel_req_o   (req_sel)
    );

    always_comb begin
        unique case (active_q)
            SEL_DIV4: half_sel = CNT_W'(HALF_DIV4);
            SEL_DIV2: half_sel = CNT_W'(HALF_DIV2);
            default:  half_sel = CNT_W'(HALF_DIV8);
        endcase
    end

    clkdiv_half_cnt #(
        .CNT_W  (CNT_W)
    ) half_cnt_i (
        .clk_i  (ref_clk_i),
        .rst_i  (rst_i),
        .run_i  (state_q == ST_DIV),
        .half_i (half_sel),
        .tick_o (tick)
    );

    assign change_pend = !act_done_i || (req_sel != active_q);
    assign pass_req    = (state_q == ST_PASS);

    // next-state and ratio load
    always_comb begin
        state_d  = state_q;
        active_d = active_q;
        unique case (state_q)
            ST_HOLD: begin
                if (act_done_i && low_cnt_q == LOW_MAX) begin
                    active_d = req_sel;
                    state_d  = (req_sel == SEL_PASS) ? ST_PASS : ST_DIV;
                end
            end
            ST_DIV:  if (change_pend && !div_q) state_d = ST_HOLD;
            ST_PASS: if (change_pend) state_d = ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    // divided clock and low-time counter
    always_comb begin
        div_d = 1'b0;
        if (state_q == ST_DIV && !(change_pend && !div_q))
            div_d = tick ? ~div_q : div_q;
        if (state_q == ST_PASS || div_d)  low_d = '0;
        else if (low_cnt_q != LOW_MAX)    low_d = low_cnt_q + 1'b1;
        else                              low_d = low_cnt_q;
    end

    always_ff @(posedge ref_clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q   <= ST_HOLD;
            active_q  <= SEL_DIV8;
            div_q     <= 1'b0;
            low_cnt_q <= '0;
        end else begin
            state_q   <= state_d;
            active_q  <= active_d;
            div_q     <= div_d;
            low_cnt_q <= low_d;
        end
    end

    clkdiv_out_gate out_gate_i (
        .ref_clk_i  (ref_clk_i),
        .rst_i      (rst_i),
        .pass_req_i (pass_req),
        .div_clk_i  (div_q),
        .clk_o      (card_clk_o)
    );

    assign ratio_ok_o = (req_sel == active_q);

    // R1: pass-through state only with the pass code in use
    assert_pass_code_R1: assert property (@(posedge ref_clk_i) disable iff (rst_i)
        (state_q == ST_PASS) |-> (active_q == SEL_PASS));

    // R4: once parked low with activation-done low, the output stays parked
    assert_gate_hold_R4: assert property (@(posedge ref_clk_i) disable iff (rst_i)
        (!act_done_i && !div_q && !pass_req) |=> (!div_q && !pass_req));

    // R6: a ratio swap follows a long enough low phase
    assert_load_low_R6: assert property (@(posedge ref_clk_i) disable iff (rst_i)
        (active_q != $past(active_q)) |->
            ($past(low_cnt_q) == LOW_MAX && !$past(div_q) && !$past(pass_req)));

    // R8: the gated reference and the divided path are never both driven
    assert_pass_excl_R8: assert property (@(posedge ref_clk_i) disable iff (rst_i)
        !(pass_req && div_q));

endmodule

// File: tb/clkdiv_card_clk_tb.sv
module clkdiv_card_clk_tb_top;

    localparam int WATCHDOG_NS = 400_000;
    // {select code, expected high/low run in half-cycle samples}
    localparam logic [5:0] VEC_TAB [5] = '{
        6'b01_0100, 6'b11_0010, 6'b10_0001, 6'b00_1000, 6'b10_0001
    };

    logic       ref_clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       act = 1'b0;
    logic       card_clk;
    logic       ratio_ok;

    int n_checks = 0;
    int n_fails  = 0;

    // monitor state (written only by the monitor, except mark)
    int run_len = 0, last_hi = 0, last_lo = 0, max_lo = 0;
    int mark = 0, seen_mark = 0;
    bit prev = 1'b0;

    always #10 ref_clk = ~ref_clk;

    clkdiv_card_clk dut_i (
        .ref_clk_i   (ref_clk),
        .rst_i       (rst),
        .ratio_sel_i (sel),
        .act_done_i  (act),
        .card_clk_o  (card_clk),
        .ratio_ok_o  (ratio_ok)
    );

    // half-cycle sampler measuring run lengths of the output
    always begin
        @(posedge ref_clk or negedge ref_clk);
        #5;
        if (mark != seen_mark) begin
            max_lo    = 0;
            seen_mark = mark;
        end
        if (card_clk == prev) run_len++;
        else begin
            if (prev) last_hi = run_len;
            else begin
                last_lo = run_len;
                if (run_len > max_lo) max_lo = run_len;
            end
            run_len = 1;
            prev    = card_clk;
        end
    end

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic count_highs(input int cycles, output int highs);
        highs = 0;
        repeat (cycles) begin
            @(posedge ref_clk); #5; if (card_clk) highs++;
            @(negedge ref_clk); #5; if (card_clk) highs++;
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge ref_clk);
        #3;
    endtask

    initial begin
        #(WATCHDOG_NS);
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int highs;
        cycles(3);
        // R3: reset state
        check(card_clk == 1'b0, "R3 clock low in reset", card_clk, 0);
        check(ratio_ok == 1'b1, "R3 flag high in reset", ratio_ok, 1);
        rst = 1'b0;
        cycles(1);
        check(card_clk == 1'b0, "R3 clock low after reset", card_clk, 0);
        // R4: silent before activation
        count_highs(30, highs);
        check(highs == 0, "R4 silent before activation", highs, 0);
        #3;
        mark++;
        act = 1'b1;
        cycles(60);
        check(last_hi == 8, "R1 divide-by-8 high run", last_hi, 8);
        check(last_lo == 8, "R2 divide-by-8 low run", last_lo, 8);
        check(ratio_ok == 1'b1, "R7 flag after start", ratio_ok, 1);
        check(max_lo >= 20, "R6 long low before first edge", max_lo, 20);

        // table walk over every code
        for (int v = 0; v < 5; v++) begin
            logic [1:0] code;
            int         exp_run;
            code    = VEC_TAB[v][5:4];
            exp_run = int'(VEC_TAB[v][3:0]);
            mark++;
            sel = code;
            cycles(16);
            check(ratio_ok == 1'b0, "R7 flag low while switching", ratio_ok, 0);
            cycles(64);
            check(ratio_ok == 1'b1, "R7 flag high after switch", ratio_ok, 1);
            check(last_hi == exp_run, (code == 2'b10) ? "R8 pass high run" : "R1 high run",
                  last_hi, exp_run);
            check(last_lo == exp_run, "R2 low run", last_lo, exp_run);
            check(max_lo >= 20, "R6 parked low across switch", max_lo, 20);
        end

        // R5: short select excursion is ignored
        sel = 2'b11;
        cycles(80);
        mark++;
        sel = 2'b01;
        cycles(5);
        sel = 2'b11;
        cycles(16);
        check(ratio_ok == 1'b1, "R5 flag unaffected by short excursion", ratio_ok, 1);
        cycles(40);
        check(last_hi == 2, "R5 rate unchanged after excursion", last_hi, 2);
        check(max_lo < 20, "R5 no reload after excursion", max_lo, 19);

        // R4: deactivation in divide-by-2
        mark++;
        act = 1'b0;
        cycles(6);
        count_highs(40, highs);
        check(highs == 0, "R4 silent while deactivated", highs, 0);
        #3;
        act = 1'b1;
        cycles(40);
        check(max_lo >= 20, "R6 long low before restart", max_lo, 20);
        check(last_hi == 2, "R4 edges resume after reactivation", last_hi, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule